// File: doc/BRIEF.md
# Quad-Precision Operand Class Tester

This block looks at one 128-bit binary128 floating-point operand and sorts it into a class. The classes are NaN, infinity, zero, subnormal and normal finite. Except for NaN, each class is also split by sign. The block then tests the class against a 7-bit class-select mask. The outcome is a 4-bit result nibble made of the operand sign, a zero, the match flag and a second zero. That nibble is written into one chosen 4-bit field of a 32-bit condition register, and the same nibble is copied into a 4-bit floating-point condition code.

A request is a one-cycle strobe carrying the operand, the mask, the field selector and the enable flag of the vector-scalar unit. The update appears one clock later, together with a one-cycle done pulse. If the unit is disabled when the request arrives, nothing is written. Instead, a one-cycle trap pulse reports that the unit is unavailable. The block does no arithmetic or rounding. Fields that are not selected keep their contents.

Top module: `qp_class_test`

## Requirements
- R1: After synchronous reset, `cond_reg`, `fp_cc`, `done` and `trap` are all zero.
- R2: Class decode uses these operand fields: `operand[127]` is the sign, `operand[126:112]` is the exponent and `operand[111:0]` is the fraction. An exponent of all ones with a nonzero fraction is NaN. NaN matches when `class_mask[0]` is set, whatever its sign.
- R3: An exponent of all ones with a zero fraction is infinity. Positive infinity matches only through `class_mask[1]`, and negative infinity matches only through `class_mask[2]`.
- R4: An exponent of zero with a zero fraction is a zero. Positive zero matches only through `class_mask[3]`, and negative zero matches only through `class_mask[4]`.
- R5: An exponent of zero with a nonzero fraction is subnormal. Positive subnormals match only through `class_mask[5]`, and negative subnormals match only through `class_mask[6]`.
- R6: A normal finite operand never matches, even when all seven mask bits are set.
- R7: The result nibble, from bit 3 down to bit 0, is {sign, 0, match, 0}. The sign is reported for every class.
- R8: Field k (k = `field_sel`, 0..7) occupies `cond_reg[31-4k : 28-4k]`, so nibble bit 3 lands in `cond_reg[31-4k]`. A write changes only that field. The other 28 bits keep their values.
- R9: On every accepted request, `fp_cc` takes the same nibble that was written into the selected field.
- R10: An accepted request (`in_valid` and `unit_en` both high) updates the outputs at the next rising edge. At that edge `done` goes high for exactly one cycle and `trap` stays low.
- R11: A request with `unit_en` low raises `trap` for one cycle at the next edge. `done` stays low, and `cond_reg` and `fp_cc` are unchanged.
- R12: While `in_valid` is low, `cond_reg` and `fp_cc` hold their values, and `done` and `trap` stay low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| operand | input | 128 | binary128 operand, sign in bit 127 |
| class_mask | input | 7 | Class-select mask, encoding as in R2 to R5 |
| field_sel | input | 3 | Condition-register field index |
| unit_en | input | 1 | Vector-scalar unit enable |
| cond_reg | output | 32 | Condition register |
| fp_cc | output | 4 | Floating-point condition code |
| done | output | 1 | One-cycle pulse marking an update |
| trap | output | 1 | One-cycle unit-unavailable pulse |

## Verification
Any fault in the class decode, the sign qualification or the mask gating shows up on the match bit `fp_cc[1]`, and on the matching field bit, one cycle after the strobe. A corrupted field register is different: it stays silent until the whole `cond_reg` word is compared. For that reason every cycle, including idle and trapped ones, compares the full register against a model. A write that lands in the wrong field, or an update that leaks through a disabled or idle cycle, then shows up within one clock.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

    parameter int EXP_W_DEF    = 15;
    parameter int FRAC_W_DEF   = 112;
    parameter int N_FIELDS_DEF = 8;
    parameter int N_CLASS      = 7;

    // class-select mask bit positions
    localparam int MB_NAN      = 0;
    localparam int MB_INF_POS  = 1;
    localparam int MB_INF_NEG  = 2;
    localparam int MB_ZERO_POS = 3;
    localparam int MB_ZERO_NEG = 4;
    localparam int MB_SUB_POS  = 5;
    localparam int MB_SUB_NEG  = 6;

    typedef enum logic [2:0] {
        K_NORMAL  = 3'd0,
        K_ZERO    = 3'd1,
        K_SUBNORM = 3'd2,
        K_INF     = 3'd3,
        K_NAN     = 3'd4
    } kind_e;

    typedef struct packed {
        logic  sign;
        kind_e kind;
    } opclass_t;

    typedef struct packed {
        logic sign;
        logic rsv_hi;
        logic hit;
        logic rsv_lo;
    } nibble_t;

    localparam int FIELD_W = $bits(nibble_t);

    function automatic nibble_t make_nibble(input logic sign, input logic hit);
        nibble_t n;
        n.sign   = sign;
        n.rsv_hi = 1'b0;
        n.hit    = hit;
        n.rsv_lo = 1'b0;
        return n;
    endfunction

    // one-hot of the sign-qualified class in mask-bit order
    function automatic logic [N_CLASS-1:0] qualify(input opclass_t c);
        logic [N_CLASS-1:0] v;
        v = '0;
        case (c.kind)
            K_NAN:     v[MB_NAN] = 1'b1;
            K_INF:     if (c.sign) v[MB_INF_NEG]  = 1'b1; else v[MB_INF_POS]  = 1'b1;
            K_ZERO:    if (c.sign) v[MB_ZERO_NEG] = 1'b1; else v[MB_ZERO_POS] = 1'b1;
            K_SUBNORM: if (c.sign) v[MB_SUB_NEG]  = 1'b1; else v[MB_SUB_POS]  = 1'b1;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/qdc_classify.sv
module qdc_classify
    import qdc_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0] operand,
    output opclass_t        cls
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    assign expo      = operand[OP_W-2 -: EXP_W];
    assign frac      = operand[FRAC_W-1:0];
    assign exp_ones  = &expo;
    assign exp_zero  = ~|expo;
    assign frac_zero = ~|frac;

    always_comb begin
        cls.sign = operand[OP_W-1];
        if (exp_ones)
            cls.kind = frac_zero ? K_INF : K_NAN;
        else if (exp_zero)
            cls.kind = frac_zero ? K_ZERO : K_SUBNORM;
        else
            cls.kind = K_NORMAL;
    end

endmodule

// File: rtl/qdc_match.sv
module qdc_match
    import qdc_pkg::*;
(
    input  opclass_t           cls,
    input  logic [N_CLASS-1:0] mask,
    output logic               hit
);

    logic [N_CLASS-1:0] qual;
    logic [N_CLASS-1:0] term;

    assign qual = qualify(cls);

    for (genvar gi = 0; gi < N_CLASS; gi++) begin : g_term
        assign term[gi] = mask[gi] & qual[gi];
    end

    assign hit = |term;

endmodule

// File: rtl/qdc_crfield.sv
module qdc_crfield
    import qdc_pkg::*;
#(
    parameter int N_FIELDS = N_FIELDS_DEF,
    localparam int CR_W    = N_FIELDS * FIELD_W,
    localparam int SEL_W   = $clog2(N_FIELDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  nibble_t          nib,
    output logic [CR_W-1:0]  cr
);

    for (genvar gf = 0; gf < N_FIELDS; gf++) begin : g_field
        logic [FIELD_W-1:0] field_q;
        logic               hit_me;

        assign hit_me = wr_en && (sel == SEL_W'(gf));

        always_ff @(posedge clk) begin
            if (rst)
                field_q <= '0;
            else if (hit_me)
                field_q <= nib;
        end

        // field 0 is the most significant nibble
        assign cr[CR_W-1-gf*FIELD_W -: FIELD_W] = field_q;

        // R8: an unselected field never moves
        assert_field_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (sel == SEL_W'(gf))) |=> $stable(cr[CR_W-1-gf*FIELD_W -: FIELD_W]));
    end

endmodule

// File: rtl/qp_class_test.sv
module qp_class_test
    import qdc_pkg::*;
#(
    parameter int EXP_W    = EXP_W_DEF,
    parameter int FRAC_W   = FRAC_W_DEF,
    parameter int N_FIELDS = N_FIELDS_DEF,
    localparam int OP_W    = 1 + EXP_W + FRAC_W,
    localparam int CR_W    = N_FIELDS * FIELD_W,
    localparam int SEL_W   = $clog2(N_FIELDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    operand,
    input  logic [N_CLASS-1:0] class_mask,
    input  logic [SEL_W-1:0]   field_sel,
    input  logic               unit_en,
    output logic [CR_W-1:0]    cond_reg,
    output logic [FIELD_W-1:0] fp_cc,
    output logic               done,
    output logic               trap
);

    opclass_t cls_w;
    logic     hit_w;
    nibble_t  nib_w;
    logic     wr_en;

    qdc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .operand (operand),
        .cls     (cls_w)
    );

    qdc_match u_match (
        .cls  (cls_w),
        .mask (class_mask),
        .hit  (hit_w)
    );

    assign nib_w = make_nibble(cls_w.sign, hit_w);
    assign wr_en = in_valid & unit_en;

    qdc_crfield #(.N_FIELDS(N_FIELDS)) u_cr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (field_sel),
        .nib   (nib_w),
        .cr    (cond_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_cc <= '0;
            done  <= 1'b0;
            trap  <= 1'b0;
        end else begin
            done <= wr_en;
            trap <= in_valid & ~unit_en;
            if (wr_en)
                fp_cc <= nib_w;
        end
    end

    function automatic logic [FIELD_W-1:0] field_of(input logic [CR_W-1:0] cr,
                                                    input logic [SEL_W-1:0] s);
        return cr[CR_W-1-FIELD_W*s -: FIELD_W];
    endfunction

    logic [EXP_W-1:0] in_exp;
    assign in_exp = operand[OP_W-2 -: EXP_W];

    assert_done_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && unit_en |=> done && !trap);

    assert_trap_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid && !unit_en |=> trap && !done && $stable(fp_cc) && $stable(cond_reg));

    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done && !trap && $stable(fp_cc) && $stable(cond_reg));

    assert_cc_copy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> field_of(cond_reg, $past(field_sel)) == fp_cc);

    assert_normal_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && unit_en && !(&in_exp) && (|in_exp) |=> !fp_cc[1]);

    assert_layout_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && unit_en |=> fp_cc[3] == $past(operand[OP_W-1]) && !fp_cc[2] && !fp_cc[0]);

    assert_nan_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && unit_en && (&in_exp) && (|operand[FRAC_W-1:0]) && class_mask[0] |=> fp_cc[1]);

endmodule

// File: tb/qp_class_test_test.sv
`timescale 1ns/1ps
module qp_class_test_test;

    typedef struct {
        logic [31:0] cr;
        logic [3:0]  cc;
        logic        dn;
        logic        tp;
        string       tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] operand = '0;
    logic [6:0]   class_mask = '0;
    logic [2:0]   field_sel = '0;
    logic         unit_en = 1'b0;
    logic [31:0]  cond_reg;
    logic [3:0]   fp_cc;
    logic         done;
    logic         trap;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    exp_t sb[$];
    logic [31:0] m_cr = '0;
    logic [3:0]  m_cc = '0;

    always #4 clk = ~clk;

    qp_class_test uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .class_mask(class_mask), .field_sel(field_sel), .unit_en(unit_en),
        .cond_reg(cond_reg), .fp_cc(fp_cc), .done(done), .trap(trap)
    );

    function automatic logic [127:0] mk(input logic s, input logic [14:0] e, input logic [111:0] f);
        return {s, e, f};
    endfunction

    function automatic logic model_hit(input logic [127:0] op, input logic [6:0] m);
        logic s, is_nan, is_inf, is_zero, is_sub;
        s       = op[127];
        is_nan  = (op[126:112] == 15'h7FFF) && (op[111:0] != 0);
        is_inf  = (op[126:112] == 15'h7FFF) && (op[111:0] == 0);
        is_zero = (op[126:112] == 15'h0000) && (op[111:0] == 0);
        is_sub  = (op[126:112] == 15'h0000) && (op[111:0] != 0);
        return (m[0] && is_nan) || (m[1] && is_inf && !s) || (m[2] && is_inf && s) ||
               (m[3] && is_zero && !s) || (m[4] && is_zero && s) ||
               (m[5] && is_sub && !s) || (m[6] && is_sub && s);
    endfunction

    task automatic step(input logic v, input logic en, input logic [127:0] op,
                        input logic [6:0] m, input logic [2:0] sel, input string tag);
        exp_t e;
        logic [3:0] nib;
        @(negedge clk);
        in_valid = v; unit_en = en; operand = op; class_mask = m; field_sel = sel;
        e.dn = v && en;
        e.tp = v && !en;
        if (v && en) begin
            nib = {op[127], 1'b0, model_hit(op, m), 1'b0};
            m_cr[31 - 4*sel -: 4] = nib;
            m_cc = nib;
        end
        e.cr = m_cr; e.cc = m_cc; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_cmp++;
                if (cond_reg !== e.cr || fp_cc !== e.cc || done !== e.dn || trap !== e.tp) begin
                    n_bad++;
                    $display("FAIL %s: actual cr=%h cc=%h done=%b trap=%b expected cr=%h cc=%h done=%b trap=%b",
                             e.tag, cond_reg, fp_cc, done, trap, e.cr, e.cc, e.dn, e.tp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_cmp++;
        if (cond_reg !== 0 || fp_cc !== 0 || done !== 0 || trap !== 0) begin
            n_bad++;
            $display("FAIL R1 reset: actual cr=%h cc=%h done=%b trap=%b expected all zero",
                     cond_reg, fp_cc, done, trap);
        end

        // R2 NaN, both signs
        step(1, 1, mk(0, 15'h7FFF, 112'h1), 7'h01, 0, "R2 +NaN mask0");
        step(1, 1, mk(1, 15'h7FFF, {1'b1, 111'h0}), 7'h01, 1, "R2 -NaN mask0");
        step(1, 1, mk(1, 15'h7FFF, 112'h55), 7'h7E, 2, "R2 NaN without mask0");
        // R3 infinity
        step(1, 1, mk(0, 15'h7FFF, 112'h0), 7'h02, 3, "R3 +inf mask1");
        step(1, 1, mk(1, 15'h7FFF, 112'h0), 7'h02, 4, "R3 -inf mask1 only");
        step(1, 1, mk(1, 15'h7FFF, 112'h0), 7'h04, 5, "R3 -inf mask2");
        step(1, 1, mk(0, 15'h7FFF, 112'h0), 7'h7D, 6, "R3 +inf without mask1");
        // R4 zero
        step(1, 1, mk(0, 15'h0, 112'h0), 7'h08, 7, "R4 +zero mask3");
        step(1, 1, mk(1, 15'h0, 112'h0), 7'h08, 0, "R4 -zero mask3 only");
        step(1, 1, mk(1, 15'h0, 112'h0), 7'h10, 1, "R4 -zero mask4");
        // R5 subnormal
        step(1, 1, mk(0, 15'h0, 112'h1), 7'h20, 2, "R5 +sub mask5");
        step(1, 1, mk(1, 15'h0, {1'b1, 111'h0}), 7'h20, 3, "R5 -sub mask5 only");
        step(1, 1, mk(1, 15'h0, 112'h3), 7'h40, 4, "R5 -sub mask6");
        step(1, 1, mk(0, 15'h0, 112'h3), 7'h5F, 5, "R5 +sub without mask5");
        // R6 normals never match, R7 sign still reported
        step(1, 1, mk(0, 15'h3FFF, 112'h0), 7'h7F, 6, "R6 +normal all mask");
        step(1, 1, mk(1, 15'h0001, 112'h0), 7'h7F, 7, "R6 R7 -normal min exp");
        step(1, 1, mk(1, 15'h7FFE, {112{1'b1}}), 7'h7F, 0, "R6 R7 -normal max exp");
        // R8 fill every field with a distinct pattern
        for (int k = 0; k < 8; k++)
            step(1, 1, mk(k[0], 15'h7FFF, 112'h0), k[0] ? 7'h04 : 7'h00, 3'(k), "R8 field sweep");
        // R11 disabled unit: trap, no change
        step(1, 0, mk(0, 15'h0, 112'h0), 7'h7F, 2, "R11 disabled request");
        step(1, 0, mk(1, 15'h7FFF, 112'h9), 7'h01, 5, "R11 disabled request 2");
        // R12 idle with busy inputs
        step(0, 1, mk(1, 15'h7FFF, 112'h1), 7'h7F, 4, "R12 idle enabled");
        step(0, 0, mk(1, 15'h0, 112'h0), 7'h10, 6, "R12 idle disabled");
        // R10 back-to-back into the same field, then R9 copy
        step(1, 1, mk(1, 15'h0, 112'h0), 7'h10, 4, "R10 back to back a");
        step(1, 1, mk(0, 15'h0, 112'h0), 7'h10, 4, "R10 back to back b");
        step(1, 1, mk(1, 15'h7FFF, 112'h2), 7'h01, 7, "R9 cc copy");
        step(0, 1, '0, '0, 0, "R10 done one cycle");
        step(0, 0, '0, '0, 0, "R12 final idle");

        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule